// File: doc/BRIEF.md
# Coincidence Pair Finder

This block takes a stream of single-photon events in arrival order. Each event carries a timestamp and a crystal identifier. The block groups the events into fixed collection frames: a frame covers 2^FRAME_SHIFT timestamp units, which is 256 units by default. When a frame is complete, the block searches it for pairs of events that arrived close together in time. Each event is compared only with the events that follow it in the same frame. The search starts from the earliest event and steps forward one event at a time until the frame is exhausted.

A pair counts as coincident when its timestamps differ by no more than a programmable window. It is reported only when the two crystals sit on detector modules that are far enough apart. For each reported pair the block emits a chord address built from the two crystal identifiers; timing is not carried in the output.

Two frame buffers alternate between roles, so the next frame fills while the previous one is searched. Both the input and the output use a valid/ready handshake:
- An input event is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` drops only when an event that would open a new frame arrives while the previous frame is still being searched. That event is held until the search ends.
- An output word is held unchanged until `out_ready` takes it.
- Output stalls pause the search without losing any pair.

Top module: `cpf_coinc_finder`

## Requirements
- R1: An event belongs to frame `in_ts >> FRAME_SHIFT`. A frame is searched only after the first event of a different frame is accepted. Pairs are never formed across frames.
- R2: Two events in one frame match when the later timestamp minus the earlier one is at most `win`. Equal timestamps match, a difference of exactly `win` matches, and `win+1` does not.
- R3: A frame stores at most DEPTH events. Each further event accepted in the same frame is discarded and raises `drop_count` by exactly one. `drop_count` changes on no other cycle.
- R4: The module number of a crystal is the upper MOD_W bits of its identifier. A matching pair is emitted only when the absolute difference of the two module numbers is at least `min_sep`.
- R5: `out_chord` holds the smaller crystal identifier in bits [2*ID_W-1:ID_W] and the larger one in bits [ID_W-1:0].
- R6: The pairs of a frame come out in order of the earlier event's position, then the later event's position. Each pair appears exactly once.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_chord` stays unchanged on the next cycle.
- R8: `in_ready` is low only while an event that opens a new frame waits for the previous frame's search to finish. That event is then accepted, and no data is lost.
- R9: After reset, `out_valid` is 0, `drop_count` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Block can take the input event |
| in_ts | input | TS_W | Event timestamp, non-decreasing |
| in_id | input | ID_W | Crystal identifier |
| win | input | WIN_W | Coincidence window in timestamp units |
| min_sep | input | MOD_W | Minimum module separation |
| out_valid | output | 1 | Chord word present |
| out_ready | input | 1 | Consumer takes the chord word |
| out_chord | output | 2*ID_W | Chord address {smaller id, larger id} |
| drop_count | output | CNT_W | Events discarded for frame overflow |

## Verification
The bench places timestamp differences of exactly `win` and `win+1`, and several events with the same timestamp. A design with an off-by-one window would miss or add pairs at those edges. Module separations of `min_sep-1` and `min_sep` are also exercised, together with pairs whose later event has the smaller identifier. A wrong geometric comparison or a swapped chord field would show up as an extra, missing or mis-encoded word.

One frame is filled past DEPTH events, which catches a buffer that overwrites or counts wrongly. Two frame closes are forced back to back so that `in_ready` must drop; a design that swapped buffers while the search was busy would corrupt the pairs. Random back-pressure on `out_ready` catches a search that advances or repeats a pair while the output is stalled.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  // Shared helpers for the coincidence pair finder
  function automatic int unsigned cpf_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cpf_frame_buf.sv
module cpf_frame_buf #(
  parameter int TS_W        = 16,
  parameter int ID_W        = 8,
  parameter int DEPTH       = 16,
  parameter int FRAME_SHIFT = 8,
  parameter int CNT_W       = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int FW = TS_W - FRAME_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [TS_W-1:0] in_ts,
  input  logic [ID_W-1:0] in_id,
  input  logic            srch_busy,
  output logic            launch,
  output logic [NW-1:0]   launch_n,
  output logic            launch_bank,
  input  logic            rd_bank,
  input  logic [IW-1:0]   rd_a,
  input  logic [IW-1:0]   rd_b,
  output logic [TS_W-1:0] a_ts,
  output logic [ID_W-1:0] a_id,
  output logic [TS_W-1:0] b_ts,
  output logic [ID_W-1:0] b_id,
  output logic [CNT_W-1:0] drop_count
);
  logic [TS_W-1:0] ts_mem [2][DEPTH];
  logic [ID_W-1:0] id_mem [2][DEPTH];
  logic            fill_bank;
  logic [NW-1:0]   fill_cnt;
  logic [FW-1:0]   cur_frame;
  logic            have_frame;

  logic [FW-1:0] in_frame;
  logic          new_frame;
  logic          accept;

  assign in_frame    = in_ts[TS_W-1:FRAME_SHIFT];
  assign new_frame   = have_frame && (in_frame != cur_frame);
  assign in_ready    = !(new_frame && srch_busy);
  assign accept      = in_valid && in_ready;
  assign launch      = accept && new_frame;
  assign launch_n    = fill_cnt;
  assign launch_bank = fill_bank;

  assign a_ts = ts_mem[rd_bank][rd_a];
  assign a_id = id_mem[rd_bank][rd_a];
  assign b_ts = ts_mem[rd_bank][rd_b];
  assign b_id = id_mem[rd_bank][rd_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_bank  <= 1'b0;
      fill_cnt   <= '0;
      cur_frame  <= '0;
      have_frame <= 1'b0;
      drop_count <= '0;
    end else if (accept) begin
      if (!have_frame || new_frame) begin
        ts_mem[fill_bank ^ new_frame][0] <= in_ts;
        id_mem[fill_bank ^ new_frame][0] <= in_id;
        fill_bank  <= fill_bank ^ new_frame;
        fill_cnt   <= NW'(1);
        cur_frame  <= in_frame;
        have_frame <= 1'b1;
      end else if (fill_cnt < NW'(DEPTH)) begin
        ts_mem[fill_bank][IW'(fill_cnt)] <= in_ts;
        id_mem[fill_bank][IW'(fill_cnt)] <= in_id;
        fill_cnt <= fill_cnt + NW'(1);
      end else begin
        drop_count <= drop_count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpf_pair_search.sv
module cpf_pair_search #(
  parameter int TS_W  = 16,
  parameter int WIN_W = 8,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [NW-1:0]    launch_n,
  input  logic             launch_bank,
  input  logic [WIN_W-1:0] win,
  input  logic [TS_W-1:0]  a_ts,
  input  logic [TS_W-1:0]  b_ts,
  input  logic             geo_ok,
  input  logic             out_free,
  output logic             busy,
  output logic             rd_bank,
  output logic [IW-1:0]    idx_a,
  output logic [IW-1:0]    idx_b,
  output logic             emit
);
  logic [NW-1:0]   n_ev;
  logic [TS_W-1:0] dt;
  logic            in_win;
  logic            stall;
  logic            last_b;

  assign dt     = b_ts - a_ts;
  assign in_win = dt <= TS_W'(win);
  assign stall  = busy && in_win && geo_ok && !out_free;
  assign emit   = busy && in_win && geo_ok && out_free;
  assign last_b = (NW'(idx_b) + NW'(1)) == n_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_bank <= 1'b0;
      n_ev    <= '0;
      idx_a   <= '0;
      idx_b   <= '0;
    end else if (!busy) begin
      if (launch && launch_n >= NW'(2)) begin
        busy    <= 1'b1;
        rd_bank <= launch_bank;
        n_ev    <= launch_n;
        idx_a   <= '0;
        idx_b   <= IW'(1);
      end
    end else if (!stall) begin
      if (last_b || !in_win) begin
        if ((NW'(idx_a) + NW'(2)) >= n_ev) begin
          busy <= 1'b0;
        end else begin
          idx_a <= idx_a + IW'(1);
          idx_b <= idx_a + IW'(2);
        end
      end else begin
        idx_b <= idx_b + IW'(1);
      end
    end
  end
endmodule

// File: rtl/cpf_chord_enc.sv
module cpf_chord_enc #(
  parameter int ID_W  = 8,
  parameter int MOD_W = 4
) (
  input  logic [ID_W-1:0]   a_id,
  input  logic [ID_W-1:0]   b_id,
  input  logic [MOD_W-1:0]  min_sep,
  output logic              geo_ok,
  output logic [2*ID_W-1:0] chord
);
  logic [MOD_W-1:0] mod_a, mod_b, sep;

  assign mod_a  = a_id[ID_W-1 -: MOD_W];
  assign mod_b  = b_id[ID_W-1 -: MOD_W];
  assign sep    = (mod_a > mod_b) ? (mod_a - mod_b) : (mod_b - mod_a);
  assign geo_ok = sep >= min_sep;
  assign chord  = (a_id <= b_id) ? {a_id, b_id} : {b_id, a_id};
endmodule

// File: rtl/cpf_coinc_finder.sv
module cpf_coinc_finder #(
  parameter int TS_W        = 16,
  parameter int ID_W        = 8,
  parameter int MOD_W       = 4,
  parameter int DEPTH       = 16,
  parameter int FRAME_SHIFT = 8,
  parameter int WIN_W       = 8,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [ID_W-1:0]   in_id,
  input  logic [WIN_W-1:0]  win,
  input  logic [MOD_W-1:0]  min_sep,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*ID_W-1:0] out_chord,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int IW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic            srch_busy, launch, launch_bank, rd_bank, geo_ok, emit, out_free;
  logic [NW-1:0]   launch_n;
  logic [IW-1:0]   idx_a, idx_b;
  logic [TS_W-1:0] a_ts, b_ts;
  logic [ID_W-1:0] a_id, b_id;
  logic [2*ID_W-1:0] chord;

  assign out_free = !out_valid || out_ready;

  cpf_frame_buf #(.TS_W(TS_W), .ID_W(ID_W), .DEPTH(DEPTH),
                  .FRAME_SHIFT(FRAME_SHIFT), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ts(in_ts), .in_id(in_id), .srch_busy(srch_busy),
    .launch(launch), .launch_n(launch_n), .launch_bank(launch_bank),
    .rd_bank(rd_bank), .rd_a(idx_a), .rd_b(idx_b),
    .a_ts(a_ts), .a_id(a_id), .b_ts(b_ts), .b_id(b_id),
    .drop_count(drop_count)
  );

  cpf_pair_search #(.TS_W(TS_W), .WIN_W(WIN_W), .DEPTH(DEPTH)) u_srch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_n(launch_n),
    .launch_bank(launch_bank), .win(win), .a_ts(a_ts), .b_ts(b_ts),
    .geo_ok(geo_ok), .out_free(out_free), .busy(srch_busy),
    .rd_bank(rd_bank), .idx_a(idx_a), .idx_b(idx_b), .emit(emit)
  );

  cpf_chord_enc #(.ID_W(ID_W), .MOD_W(MOD_W)) u_enc (
    .a_id(a_id), .b_id(b_id), .min_sep(min_sep), .geo_ok(geo_ok), .chord(chord)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chord <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_chord <= chord;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cpf_coinc_finder_chk.sv
module cpf_coinc_finder_chk #(
  parameter int ID_W  = 8,
  parameter int MOD_W = 4,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [MOD_W-1:0]  min_sep,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*ID_W-1:0] out_chord,
  input logic [CNT_W-1:0]  drop_count
);
  logic [ID_W-1:0]  lo_id, hi_id;
  logic [MOD_W-1:0] lo_mod, hi_mod, gap;
  assign lo_id  = out_chord[2*ID_W-1:ID_W];
  assign hi_id  = out_chord[ID_W-1:0];
  assign lo_mod = lo_id[ID_W-1 -: MOD_W];
  assign hi_mod = hi_id[ID_W-1 -: MOD_W];
  assign gap    = (lo_mod > hi_mod) ? (lo_mod - hi_mod) : (hi_mod - lo_mod);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chord));

  p_chord_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lo_id <= hi_id);

  p_geom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gap >= min_sep);

  p_drop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (drop_count == $past(drop_count)) ||
                             (drop_count == $past(drop_count) + CNT_W'(1)));

  p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(drop_count));
endmodule

bind cpf_coinc_finder cpf_coinc_finder_chk #(.ID_W(ID_W), .MOD_W(MOD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .min_sep(min_sep), .out_valid(out_valid), .out_ready(out_ready),
  .out_chord(out_chord), .drop_count(drop_count)
);

// File: tb/test_cpf_coinc_finder.sv
module test_cpf_coinc_finder;
  localparam int WINV = 10;
  localparam int SEPV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_ts = '0;
  logic [7:0]  in_id = '0;
  logic [7:0]  win = 8'(WINV);
  logic [3:0]  min_sep = 4'(SEPV);
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] out_chord;
  logic [15:0] drop_count;

  always #10 clk = ~clk;

  cpf_coinc_finder i_cpf_coinc_finder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ts(in_ts), .in_id(in_id), .win(win), .min_sep(min_sep),
    .out_valid(out_valid), .out_ready(out_ready), .out_chord(out_chord),
    .drop_count(drop_count)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit stall_seen = 0;

  // behavioural model state
  int fq_ts[$];
  int fq_id[$];
  int cur_f = -1;
  int m_drop = 0;
  logic [15:0] exp_q[$];
  logic prev_hold = 0;
  logic [15:0] prev_chord = '0;

  task automatic close_frame();
    for (int i = 0; i < fq_ts.size(); i++)
      for (int j = i + 1; j < fq_ts.size(); j++) begin
        int ma, mb, d;
        if (fq_ts[j] - fq_ts[i] > WINV) break;
        ma = fq_id[i] / 16; mb = fq_id[j] / 16;
        d = (ma > mb) ? ma - mb : mb - ma;
        if (d >= SEPV)
          exp_q.push_back((fq_id[i] <= fq_id[j]) ? 16'(fq_id[i] * 256 + fq_id[j])
                                                  : 16'(fq_id[j] * 256 + fq_id[i]));
      end
    fq_ts.delete(); fq_id.delete();
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      // R7: a stalled word must be held
      if (prev_hold) begin
        n_cmp++;
        if (!out_valid || out_chord != prev_chord) begin
          n_bad++;
          $display("FAIL R7 hold: valid=%0b chord=%h expected valid=1 chord=%h", out_valid, out_chord, prev_chord);
        end
      end
      if (out_valid && out_ready) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R1 R6 unexpected word: actual=%h expected=none", out_chord);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (e != out_chord) begin
            n_bad++;
            $display("FAIL R2 R4 R5 R6 chord: actual=%h expected=%h", out_chord, e);
          end
        end
      end
      if (in_valid && in_ready) begin
        int f;
        f = int'(in_ts) / 256;
        if (cur_f >= 0 && f != cur_f) close_frame();
        cur_f = f;
        if (fq_ts.size() < 16) begin
          fq_ts.push_back(int'(in_ts)); fq_id.push_back(int'(in_id));
        end else m_drop++;
      end
      prev_hold = out_valid && !out_ready;
      prev_chord = out_chord;
    end
  end

  // R3: drop counter compared every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (int'(drop_count) != m_drop) begin
        n_bad++;
        $display("FAIL R3 drop_count: actual=%0d expected=%0d", drop_count, m_drop);
      end
      out_ready <= ($urandom % 10) < 7;
    end
  end

  task automatic send(input int ts, input int id);
    logic r;
    @(negedge clk);
    in_valid = 1'b1; in_ts = 16'(ts); in_id = 8'(id);
    forever begin
      #1 r = in_ready;
      if (!r) stall_seen = 1;
      @(posedge clk);
      if (r) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || drop_count !== 16'd0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 reset: valid=%b drop=%0d ready=%b expected 0 0 1", out_valid, drop_count, in_ready);
    end
    // Frame 0: window edges, equal stamps, separation edges, swapped ids (R2 R4 R5)
    send(10, 'h12); send(15, 'h35); send(20, 'h20); send(20, 'h71);
    send(21, 'h05); send(30, 'h05); send(31, 'h92);
    // Frame 1: overflow past 16 events (R3)
    for (int k = 0; k < 20; k++) send(256 + k * 3, (k * 37 + 5) % 256);
    // Frame 2 then frame 3 back to back: input stall (R8), frame isolation (R1)
    send(512, 'h10); send(514, 'hF0); send(600, 'h44);
    send(768, 'h01); send(770, 'h61);
    // Random frames (R6)
    for (int f = 4; f < 10; f++) begin
      int t, cnt;
      cnt = 1 + int'($urandom % 20);
      t = f * 256 + int'($urandom % 8);
      for (int k = 0; k < cnt; k++) begin
        send(t, int'($urandom % 256));
        t = t + int'($urandom % 12);
        if (t > f * 256 + 255) t = f * 256 + 255;
      end
    end
    send(20 * 256, 'h00);
    for (int w = 0; w < 3000; w++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !out_valid) break;
    end
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 missing words: actual=%0d left expected=0", exp_q.size());
    end
    n_cmp++;
    if (!stall_seen) begin
      n_bad++;
      $display("FAIL R8 stall: actual=no stall expected=in_ready low");
    end
    finish_run();
  end
endmodule